// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small binary counter driven by two separate count strobes instead of an enable and a direction bit. A rising edge on the up strobe adds one to the count. A rising edge on the down strobe subtracts one. While a strobe is not in use it rests high. Both strobes are sampled on one system clock through a two-flop synchronizer, and the block acts on the rising edges it detects there.

An active-high clear and an active-low parallel load override counting. Each one appears on the count output in the same cycle it is asserted. The block has two active-low terminal outputs. The carry output is low only while the count is at its maximum and the up strobe is low. The borrow output is low only while the count is zero and the down strobe is low. When a strobe rises, the matching terminal output rises with it. Because of this, the carry and borrow outputs of one stage can drive the up and down strobes of the next stage, and stages chain into a wider ripple counter.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb_i` increments the count by one, and the maximum value (15 at WIDTH=4) wraps to 0.
- R2: A rising edge on `dn_stb_i` decrements the count by one, and 0 wraps to the maximum value.
- R3: While `clear_i` is high, `count_o` is 0 in the same cycle, whatever the load, data and strobe inputs are.
- R4: While `load_n_i` is low and `clear_i` is low, `count_o` equals `data_i` in the same cycle. The loaded value is held after `load_n_i` returns high.
- R5: Strobe edges that occur while clear or load is active have no effect. A strobe that is already high when the override is released does not count.
- R6: If rising edges of both strobes are detected in the same cycle, the count is left unchanged.
- R7: `carry_n_o` is 0 only while the count is at its maximum and the synchronized up strobe is low. Otherwise it is 1, and it returns to 1 when the up strobe rises.
- R8: `borrow_n_o` is 0 only while the count is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R9: After the synchronous reset `rst_n` is low at a clock edge, the count is 0 and both terminal outputs are 1.
- R10: When the carry and borrow outputs of one stage drive the up and down strobes of a second stage, the pair counts as one 8-bit value. This holds across the 255-to-0 step and the 0-to-255 step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Master clear, active high, overrides everything |
| load_n_i | input | 1 | Parallel load, active low |
| data_i | input | WIDTH | Parallel load value |
| up_stb_i | input | 1 | Count-up strobe, acts on its rising edge, idles high |
| dn_stb_i | input | 1 | Count-down strobe, acts on its rising edge, idles high |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Terminal count up, active low |
| borrow_n_o | output | 1 | Terminal count down, active low |

## Verification
The bench builds the block with the default WIDTH of 4 and a two-stage synchronizer. With these values both wrap points and both terminal states are reached in a few strobe pulses. With a narrow count, two instances chained through carry and borrow form an 8-bit counter. The bench drives that counter directly across its 255/0 boundary in both directions. The bench also keeps a strobe high across the release of a load, so the rule against false edges is exercised.

// File: rtl/updn_pkg.sv
// Package: shared types for the dual-strobe counter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package updn_pkg;

    // Step the count register takes in one cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_SET  = 2'd3
    } step_e;

endpackage

// File: rtl/strobe_edge.sv
// strobe_edge: brings one asynchronous strobe into the clock domain through a
// STAGES-deep synchronizer. It reports the synchronized level and a one-cycle
// rise pulse. Assumes the strobe idles high, so the reset value of every
// stage is 1. The previous-level flop is always updated, which means that
// after an override is released, edge detection continues from the current
// level.
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], stb_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Report the level and the rising-edge pulse.
    always_comb begin
        level_o = sync_q[STAGES-1];
        rise_o  = sync_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/count_core.sv
// count_core: holds the count register and applies the priority
// clear > load > count. Clear and load also drive the output directly, so
// they take effect in the cycle they are asserted. Assumes the edge inputs
// are single-cycle pulses.
module count_core
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             up_rise_i,
    input  logic             dn_rise_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] set_val;
    step_e            step;

    // Choose this cycle's step from overrides and strobe edges.
    always_comb begin
        set_val = clear_i ? '0 : data_i;
        if (clear_i || !load_n_i)       step = STEP_SET;
        else if (up_rise_i && !dn_rise_i) step = STEP_INC;
        else if (dn_rise_i && !up_rise_i) step = STEP_DEC;
        else                              step = STEP_HOLD;
    end

    // Update the count register; wrap comes from modular arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (step)
                STEP_SET: cnt_q <= set_val;
                STEP_INC: cnt_q <= cnt_q + ONE;
                STEP_DEC: cnt_q <= cnt_q - ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // An active override drives the output directly.
    always_comb begin
        count_o = (step == STEP_SET) ? set_val : cnt_q;
    end
endmodule

// File: rtl/term_detect.sv
// term_detect: produces the active-low carry and borrow outputs from the
// visible count and the synchronized strobe levels. Assumes the levels come
// from the same synchronizer that feeds edge detection, so a terminal output
// rises in the same cycle the count starts to move.
module term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic             up_level_i,
    input  logic             dn_level_i,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    // Low only in the terminal state while the matching strobe is low.
    always_comb begin
        carry_n_o  = ~((&count_i)  & ~up_level_i);
        borrow_n_o = ~((~|count_i) & ~dn_level_i);
    end
endmodule

// File: rtl/updn_strobe_counter.sv
// updn_strobe_counter: up/down counter driven by two rising-edge strobes,
// with master clear, parallel load and active-low carry and borrow outputs
// that can strobe a following stage. Assumes the strobes are never low
// together during normal counting and that both idle high.
module updn_strobe_counter #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             up_stb_i,
    input  logic             dn_stb_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    logic up_lvl, dn_lvl, up_edge, dn_edge;

    strobe_edge #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .stb_i(up_stb_i),
        .level_o(up_lvl), .rise_o(up_edge)
    );

    strobe_edge #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .stb_i(dn_stb_i),
        .level_o(dn_lvl), .rise_o(dn_edge)
    );

    count_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
        .data_i(data_i), .up_rise_i(up_edge), .dn_rise_i(dn_edge),
        .count_o(count_o)
    );

    term_detect #(.WIDTH(WIDTH)) u_term (
        .count_i(count_o), .up_level_i(up_lvl), .dn_level_i(dn_lvl),
        .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
    );
endmodule

// File: rtl/updn_strobe_counter_chk.sv
// updn_strobe_counter_chk: assertion checker bound to every counter instance.
// It watches the ports and the synchronized strobe levels and edges.
module updn_strobe_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             load_n_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             up_edge,
    input logic             dn_edge
);
    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_edge && !dn_edge && !clear_i && load_n_i) |=>
        (clear_i || !load_n_i || count_o == WIDTH'($past(count_o) + 1'b1)));

    // R2
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_edge && !up_edge && !clear_i && load_n_i) |=>
        (clear_i || !load_n_i || count_o == WIDTH'($past(count_o) - 1'b1)));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> (count_o == '0));

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_n_i) |-> (count_o == data_i));

    // R5
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_edge && !dn_edge) |=> (clear_i || !load_n_i || $stable(count_o)));

    // R6
    both_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_edge && dn_edge) |=> (clear_i || !load_n_i || $stable(count_o)));

    // R7
    carry_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == '1));

    // R8
    borrow_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == '0));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (clear_i || !load_n_i ||
                    (count_o == '0 && carry_n_o && borrow_n_o)));
endmodule

bind updn_strobe_counter updn_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
    .data_i(data_i), .count_o(count_o), .carry_n_o(carry_n_o),
    .borrow_n_o(borrow_n_o), .up_edge(up_edge), .dn_edge(dn_edge)
);

// File: tb/updn_strobe_counter_tb.sv
`timescale 1ns/1ps
module updn_strobe_counter_tb;
    localparam int W = 4;
    localparam logic [1:0] OP_UP = 2'd0, OP_DN = 2'd1, OP_LD = 2'd2, OP_CL = 2'd3;
    localparam int NV = 12;
    // {op, data, expected count}
    localparam logic [9:0] VEC [NV] = '{
        {OP_CL, 4'd0,  4'd0},  {OP_LD, 4'd5,  4'd5},  {OP_UP, 4'd0, 4'd6},
        {OP_UP, 4'd0,  4'd7},  {OP_DN, 4'd0,  4'd6},  {OP_LD, 4'd14, 4'd14},
        {OP_UP, 4'd0,  4'd15}, {OP_UP, 4'd0,  4'd0},  {OP_DN, 4'd0, 4'd15},
        {OP_LD, 4'd0,  4'd0},  {OP_DN, 4'd0,  4'd15}, {OP_CL, 4'd0, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, load_n = 1'b1, up = 1'b1, dn = 1'b1;
    logic [W-1:0] data = '0;
    logic [W-1:0] count;
    logic carry_n, borrow_n;
    logic hi_load_n = 1'b1;
    logic [W-1:0] hi_data = '0;
    logic [W-1:0] hi_count;
    logic hi_carry_n, hi_borrow_n;
    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    updn_strobe_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .load_n_i(load_n),
        .data_i(data), .up_stb_i(up), .dn_stb_i(dn), .count_o(count),
        .carry_n_o(carry_n), .borrow_n_o(borrow_n)
    );

    // Upper stage, strobed by the lower stage's terminal outputs (R10).
    updn_strobe_counter #(.WIDTH(W)) u_hi (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .load_n_i(hi_load_n),
        .data_i(hi_data), .up_stb_i(carry_n), .dn_stb_i(borrow_n),
        .count_o(hi_count), .carry_n_o(hi_carry_n), .borrow_n_o(hi_borrow_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit is_up);
        if (is_up) up = 1'b0; else dn = 1'b0;
        wait_n(4);
        if (is_up) up = 1'b1; else dn = 1'b1;
        wait_n(4);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_n = 1'b0; data = v;
        #1 check("R4 immediate load", 8'(count), 8'(v));
        wait_n(1);
        load_n = 1'b1;
        wait_n(1);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        #1 check("R3 immediate clear", 8'(count), 8'd0);
        wait_n(1);
        clear = 1'b0;
        wait_n(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R9 reset state
        check("R9 count", 8'(count), 8'd0);
        check("R9 carry", 8'(carry_n), 8'd1);
        check("R9 borrow", 8'(borrow_n), 8'd1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][9:8])
                OP_UP: begin pulse(1'b1); check("R1 table", 8'(count), 8'(VEC[i][3:0])); end
                OP_DN: begin pulse(1'b0); check("R2 table", 8'(count), 8'(VEC[i][3:0])); end
                OP_LD: begin do_load(VEC[i][7:4]); check("R4 table", 8'(count), 8'(VEC[i][3:0])); end
                default: begin do_clear(); check("R3 table", 8'(count), 8'(VEC[i][3:0])); end
            endcase
        end

        // R3: clear overrides an active load
        load_n = 1'b0; data = 4'd9; clear = 1'b1;
        #1 check("R3 over load", 8'(count), 8'd0);
        wait_n(1);
        clear = 1'b0;
        #1 check("R4 after clear", 8'(count), 8'd9);
        // R5: strobe pulse during load is ignored; up high at release
        wait_n(1);
        pulse(1'b1);
        load_n = 1'b1;
        wait_n(5);
        check("R5 load ignores edge", 8'(count), 8'd9);
        clear = 1'b1;
        pulse(1'b0);
        clear = 1'b0;
        wait_n(5);
        check("R5 clear ignores edge", 8'(count), 8'd0);

        // R6: both edges in one cycle
        do_load(4'd7);
        up = 1'b0; dn = 1'b0;
        wait_n(4);
        up = 1'b1; dn = 1'b1;
        wait_n(4);
        check("R6 both edges", 8'(count), 8'd7);

        // R7 carry
        do_load(4'd15);
        check("R7 carry idle high", 8'(carry_n), 8'd1);
        up = 1'b0;
        wait_n(4);
        check("R7 carry low", 8'(carry_n), 8'd0);
        check("R8 borrow stays high", 8'(borrow_n), 8'd1);
        up = 1'b1;
        wait_n(4);
        check("R7 carry released", 8'(carry_n), 8'd1);
        check("R1 wrap", 8'(count), 8'd0);
        // R8 borrow
        dn = 1'b0;
        wait_n(4);
        check("R8 borrow low", 8'(borrow_n), 8'd0);
        dn = 1'b1;
        wait_n(4);
        check("R8 borrow released", 8'(borrow_n), 8'd1);
        check("R2 wrap", 8'(count), 8'd15);

        // R10 cascade across 255/0
        do_clear();
        hi_load_n = 1'b0; hi_data = 4'd15;
        do_load(4'd15);
        hi_load_n = 1'b1;
        wait_n(2);
        check("R10 start 255", {hi_count, count}, 8'd255);
        up = 1'b0; wait_n(4); up = 1'b1; wait_n(10);
        check("R10 255 to 0", {hi_count, count}, 8'd0);
        dn = 1'b0; wait_n(4); dn = 1'b1; wait_n(10);
        check("R10 0 to 255", {hi_count, count}, 8'd255);
        up = 1'b0; wait_n(4); up = 1'b1; wait_n(10);
        up = 1'b0; wait_n(4); up = 1'b1; wait_n(10);
        check("R10 carry into upper", {hi_count, count}, 8'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule